// File: doc/BRIEF.md
# Transition Pulse Encoder With Refresh

This block is the transmit half of a one-bit isolated link whose channel passes only short pulses and never a steady level. It watches a single asynchronous logic input, synchronises it, and turns every change of level into a short pulse on one of two outputs. A pulse on `link_set_o` means "the level is now high" and a pulse on `link_clr_o` means "the level is now low". A receiver can therefore rebuild the level with a simple set/reset latch.

A static input produces no edges, so the far side could drift after a disturbance. To prevent this, the block keeps an idle timer. Once `REFRESH_CYCLES` clocks pass without a pulse, it sends a refresh pulse whose polarity matches the present level. After reset, and each time the enable returns, it sends one pulse at once, so the receiver does not wait a full refresh period to learn the state.

The input is a plain level and the outputs are single-cycle strobes with no back-pressure, so there is no valid/ready handshake. `en_i` stands in for the input side being powered: while it is low, nothing is sent.

Top module: `transition_pulse_encoder`

## Requirements
- R1: While `rst_i` is high, and for the first two clock edges after it is released, both pulse outputs are low.
- R2: A low-to-high change of `din_i` held at least `MIN_PW_CYCLES` produces a pulse on `link_set_o`. The pulse starts at the third rising clock edge after the change and lasts `PULSE_CYCLES` cycles.
- R3: A high-to-low change of `din_i` produces a `link_clr_o` pulse with the same latency and length as in R2.
- R4: When no pulse has started for `REFRESH_CYCLES` cycles while enabled, a refresh pulse starts exactly `REFRESH_CYCLES` cycles after the previous one. It goes out on `link_set_o` if the synchronised level is 1 and on `link_clr_o` if it is 0, and it repeats at that spacing while the input stays idle.
- R5: Every pulse restarts the idle timer, so the first refresh after an edge pulse comes `REFRESH_CYCLES` cycles after that edge pulse.
- R6: When an edge pulse and a refresh fall due on the same cycle, exactly one pulse is sent. It carries the new level's polarity, and the next refresh is timed from it.
- R7: `link_set_o` and `link_clr_o` are never high in the same cycle.
- R8: After reset release, a pulse starts at the third rising edge, with the polarity of `din_i` as held across the release.
- R9: While `en_i` is low, both outputs stay low and input changes send nothing. At the first clock edge that samples `en_i` high again, one pulse with the current synchronised level's polarity starts, and the idle timer restarts.
- R10: Input pulses as short as `MIN_PW_CYCLES` cycles each yield their own pulse: a set pulse for the leading edge and a clear pulse for the trailing edge, `MIN_PW_CYCLES` cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Input side active; low suppresses all pulses |
| din_i | input | 1 | Asynchronous logic level to be carried |
| link_set_o | output | 1 | Pulse meaning "level is high" |
| link_clr_o | output | 1 | Pulse meaning "level is low" |

## Verification
The assertions assume that `din_i` holds each level for at least `MIN_PW_CYCLES` clocks. They also assume the parameters keep `PULSE_CYCLES` no larger than `MIN_PW_CYCLES` and below `REFRESH_CYCLES`, so that two pulses never compete for the shaper. The random stimulus draws every hold time from `MIN_PW_CYCLES` upward, reaching past one refresh period so that idle refreshes occur. It toggles `en_i` only at segment boundaries. The directed cases place an edge exactly on a due refresh and a minimum-width input pulse to probe the corners.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_EDGE     = 2'd1,
    EV_ANNOUNCE = 2'd2,
    EV_REFRESH  = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic     fire;
    logic     pol;
    ev_kind_e kind;
  } ev_t;

endpackage

// File: rtl/tpe_sync.sv
module tpe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tpe_refresh_timer.sv
module tpe_refresh_timer #(
  parameter int REFRESH_CYCLES = 250
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic restart_i,
  output logic due_o
);
  localparam int CW = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i || restart_i) idle_q <= '0;
    else if (idle_q != LAST)          idle_q <= idle_q + 1'b1;
  end

  assign due_o = run_i && (idle_q == LAST);

  AST_IDLE_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    due_o |=> (idle_q == '0) || !$past(run_i)) else $error("idle timer kept counting after due"); // R5
endmodule

// File: rtl/tpe_event_unit.sv
module tpe_event_unit
  import tpe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic lvl_i,
  input  logic due_i,
  output logic warm_o,
  output ev_t  ev_o
);
  localparam int WW = $clog2(SYNC_STAGES + 1);
  localparam logic [WW-1:0] WARM_AT = WW'(SYNC_STAGES);

  logic [WW-1:0] warm_q;
  logic          lvl_q;
  logic          owed_q;
  logic          edge_seen;

  always_ff @(posedge clk_i) begin
    if (rst_i)                 warm_q <= '0;
    else if (warm_q != WARM_AT) warm_q <= warm_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) lvl_q <= 1'b0;
    else       lvl_q <= lvl_i;
  end

  assign warm_o    = (warm_q == WARM_AT);
  assign edge_seen = warm_o && (lvl_i != lvl_q);

  always_comb begin
    ev_o.pol  = lvl_i;
    ev_o.fire = 1'b0;
    ev_o.kind = EV_NONE;
    if (en_i && warm_o) begin
      if (edge_seen) begin
        ev_o.fire = 1'b1;
        ev_o.kind = EV_EDGE;
      end else if (owed_q) begin
        ev_o.fire = 1'b1;
        ev_o.kind = EV_ANNOUNCE;
      end else if (due_i) begin
        ev_o.fire = 1'b1;
        ev_o.kind = EV_REFRESH;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)          owed_q <= 1'b1;
    else if (!en_i)     owed_q <= 1'b1;
    else if (ev_o.fire) owed_q <= 1'b0;
  end

  AST_ANNOUNCE_ON_WARM: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(warm_o) && en_i) |-> ev_o.fire) else $error("no pulse after reset"); // R8
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && edge_seen && due_i) |-> (ev_o.kind == EV_EDGE)) else $error("refresh beat edge"); // R6
endmodule

// File: rtl/tpe_pulse_gen.sv
module tpe_pulse_gen #(
  parameter int PULSE_CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic pol_i,
  output logic active_o,
  output logic pol_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] LEN = PW'(PULSE_CYCLES);

  logic [PW-1:0] left_q;
  logic          pol_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_q <= '0;
      pol_q  <= 1'b0;
    end else if (load_i) begin
      left_q <= LEN;
      pol_q  <= pol_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active_o = (left_q != '0);
  assign pol_o    = pol_q;

  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (left_q <= LEN)) else $error("pulse length overrun"); // R2
  AST_POL_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_o && !load_i) |=> $stable(pol_q)) else $error("polarity changed mid pulse"); // R7
endmodule

// File: rtl/transition_pulse_encoder.sv
module transition_pulse_encoder
  import tpe_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int PULSE_CYCLES   = 1,
  parameter int MIN_PW_CYCLES  = 3,
  parameter int REFRESH_CYCLES = 250
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic din_i,
  output logic link_set_o,
  output logic link_clr_o
);
  generate
    if (PULSE_CYCLES < 1 || PULSE_CYCLES > MIN_PW_CYCLES ||
        REFRESH_CYCLES <= PULSE_CYCLES || SYNC_STAGES < 1) begin : g_bad_params
      $error("transition_pulse_encoder: inconsistent parameters");
    end
  endgenerate

  logic sync_lvl;
  logic warm;
  logic due;
  logic pg_active;
  logic pg_pol;
  ev_t  ev;

  tpe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (din_i),
    .q_o   (sync_lvl)
  );

  tpe_event_unit #(.SYNC_STAGES(SYNC_STAGES)) u_event (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .lvl_i  (sync_lvl),
    .due_i  (due),
    .warm_o (warm),
    .ev_o   (ev)
  );

  tpe_refresh_timer #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_i     (en_i && warm),
    .restart_i (ev.fire),
    .due_o     (due)
  );

  tpe_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (ev.fire),
    .pol_i    (ev.pol),
    .active_o (pg_active),
    .pol_o    (pg_pol)
  );

  assign link_set_o = en_i && pg_active && pg_pol;
  assign link_clr_o = en_i && pg_active && !pg_pol;

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    !(link_set_o && link_clr_o)) else $error("both outputs high"); // R7
  AST_RISE_TO_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev.fire && ev.pol) |=> (pg_active && pg_pol)) else $error("high event lost"); // R2
  AST_FALL_TO_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev.fire && !ev.pol) |=> (pg_active && !pg_pol)) else $error("low event lost"); // R3
  AST_REFRESH_SENT: assert property (@(posedge clk_i) disable iff (rst_i)
    (due && en_i) |-> ev.fire) else $error("refresh not sent"); // R4
  AST_QUIET_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> !ev.fire) else $error("event while disabled"); // R9
endmodule

// File: tb/transition_pulse_encoder_test.sv
module transition_pulse_encoder_test;
  localparam int SYNC = 2;
  localparam int PL   = 1;
  localparam int MPW  = 3;
  localparam int RF   = 250;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic din = 1'b0;
  logic set_o, clr_o;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  transition_pulse_encoder #(
    .SYNC_STAGES(SYNC), .PULSE_CYCLES(PL), .MIN_PW_CYCLES(MPW), .REFRESH_CYCLES(RF)
  ) uut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .din_i(din),
    .link_set_o(set_o), .link_clr_o(clr_o)
  );

  // Reference built from the requirements: 2-flop latency plus a registered pulse.
  logic m1, m2, m3, m_owed, m_sign;
  int unsigned m_age, m_quiet, m_left;

  always @(posedge clk) begin
    if (rst) begin
      m1 = 0; m2 = 0; m3 = 0; m_age = 0; m_owed = 1; m_quiet = 0; m_left = 0; m_sign = 0;
    end else begin
      bit ready, go;
      ready = (m_age >= SYNC);
      go = ready && en && ((m2 != m3) || m_owed || (m_quiet == RF - 1));
      if (m_left > 0) m_left--;
      if (go) begin m_left = PL; m_sign = m2; end
      if (!en) m_owed = 1; else if (go) m_owed = 0;
      if (!ready || !en || go) m_quiet = 0; else m_quiet++;
      m3 = m2; m2 = m1; m1 = din;
      if (m_age < SYNC) m_age++;
    end
  end

  function automatic logic exp_set();
    return en && (m_left != 0) && m_sign;
  endfunction
  function automatic logic exp_clr();
    return en && (m_left != 0) && !m_sign;
  endfunction

  task automatic check(input string req, input logic as, input logic ac,
                       input logic es, input logic ec);
    n_run++;
    if (as !== es || ac !== ec) begin
      n_fail++;
      if (n_fail < 30)
        $display("FAIL %s at %0t: set/clr=%b%b expected %b%b", req, $time, as, ac, es, ec);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && !done) begin
      check("R7 exclusive", set_o && clr_o, 1'b0, 1'b0, 1'b0);
      check("model R2 R3 R4 R5 R9", set_o, clr_o, exp_set(), exp_clr());
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250917));
    step(3);
    check("R1 reset", set_o, clr_o, 1'b0, 1'b0);
    rst = 1'b0;
    mon_on = 1'b1;
    step(1); check("R1 release+1", set_o, clr_o, 1'b0, 1'b0);
    step(1); check("R1 release+2", set_o, clr_o, 1'b0, 1'b0);
    step(1); check("R8 announce low", set_o, clr_o, 1'b0, 1'b1);
    step(RF - 1); check("R4 quiet before refresh", set_o, clr_o, 1'b0, 1'b0);
    step(1); check("R4 refresh low", set_o, clr_o, 1'b0, 1'b1);
    din = 1'b1;
    step(2); check("R2 latency", set_o, clr_o, 1'b0, 1'b0);
    step(1); check("R2 set pulse", set_o, clr_o, 1'b1, 1'b0);
    step(1); check("R2 pulse length", set_o, clr_o, 1'b0, 1'b0);
    step(RF - 1); check("R5 refresh high after edge", set_o, clr_o, 1'b1, 1'b0);
    step(RF - 3); din = 1'b0;
    step(3); check("R6 edge over refresh", set_o, clr_o, 1'b0, 1'b1);
    step(RF); check("R6 timer restarted", set_o, clr_o, 1'b0, 1'b1);
    step(1); din = 1'b1;
    step(3); check("R10 leading edge", set_o, clr_o, 1'b1, 1'b0);
    din = 1'b0;
    step(1); check("R3 gap", set_o, clr_o, 1'b0, 1'b0);
    step(2); check("R10 trailing edge", set_o, clr_o, 1'b0, 1'b1);
    step(5);
    en = 1'b0;
    begin
      bit quiet_ok = 1'b1;
      for (int i = 0; i < 2 * RF; i++) begin
        if (i % 40 == 5) din = ~din;
        step(1);
        if (set_o || clr_o) quiet_ok = 1'b0;
      end
      din = 1'b1;
      step(5);
      if (set_o || clr_o) quiet_ok = 1'b0;
      check("R9 silent while disabled", quiet_ok, 1'b0, 1'b1, 1'b0);
    end
    en = 1'b1;
    step(1); check("R9 announce on enable", set_o, clr_o, 1'b1, 1'b0);

    for (int seg = 0; seg < 150; seg++) begin
      int unsigned hold;
      hold = MPW + ($urandom % (RF + RF / 2));
      din = ~din;
      if ($urandom % 10 == 0) en = ~en;
      step(hold);
    end
    en = 1'b1;
    step(10);
    finish_run();
  end
endmodule